// File: doc/BRIEF.md
# Cubic INL correction code generator

This block sits beside the data path of a high-resolution DAC and computes, for every 14-bit code that goes to that converter, a small signed correction code for a low-resolution auxiliary DAC. The auxiliary DAC's output is summed with the main DAC's output in the analog domain. The correction is a cubic polynomial in the input code. Its four coefficients come from registers that an off-line calibration routine fills in. With a correct fit, the residual integral nonlinearity drops from about ±1.5 LSB to within ±0.5 LSB.

The polynomial is evaluated in Horner form over a four-register pipeline and accepts one sample per clock. The input code is first re-centred on mid-scale. Each Horner step multiplies the running sum by the normalised offset and adds the next coefficient. The final stage rounds the result to the auxiliary DAC step and clamps it to the 6-bit signed range.

Both stream edges use valid/ready. A sample transfers on a rising edge where both valid and ready are high. When `out_valid` is high and `out_ready` is low, the whole pipeline stalls. The output register then holds its code, and `in_ready` is low, so no sample is lost, dropped or duplicated. `in_ready` depends only on `out_valid` and `out_ready`, never on `in_valid`.

Top module: `inl_corr_gen`

## Requirements
- R1: The input code is read as a signed offset from mid-scale, x = code − 8192. Code 0 gives x = −8192, and code 16383 gives x = +8191.
- R2: Each coefficient is an 18-bit two's-complement value with 12 fractional bits, in units of one auxiliary-DAC step. Evaluation starts from t = b3. It then applies t ← floor(t·x / 8192) + bk for k = 2, 1, 0 in that order.
- R3: A sample accepted on a rising edge gives `out_valid` high after the fourth rising edge, counting the accepting edge. With `out_ready` held high, the block accepts and delivers one sample per clock.
- R4: The final value t is rounded to the nearest whole step. A tie at exactly half a step goes toward +∞, so 2.5 gives 3 and −2.5 gives −2.
- R5: The rounded value is clamped to −32…+31 and driven as a 6-bit two's-complement `out_code`.
- R6: While `cal_en` is low, `out_code` reads 0 in the same cycle, and `out_valid` and the handshake are not affected. Raising `cal_en` shows the held result at once.
- R7: While `out_valid` is high and `out_ready` is low, `out_code` and `out_valid` hold and `in_ready` is low. The output stream is the input stream in the same order, with nothing lost or repeated.
- R8: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Correction enable; when low, the output code reads zero |
| coef_b0 | input | 18 | Constant term, signed, 12 fractional bits |
| coef_b1 | input | 18 | Linear term, signed, 12 fractional bits |
| coef_b2 | input | 18 | Square term, signed, 12 fractional bits |
| coef_b3 | input | 18 | Cubic term, signed, 12 fractional bits |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_code | input | 14 | Main DAC code, unsigned |
| out_valid | output | 1 | Correction code present |
| out_ready | input | 1 | Consumer takes the code |
| out_code | output | 6 | Correction code, signed |

## Verification
The assertions assume that the coefficients stay constant while samples are in flight, because a sample meets each coefficient at a different pipeline stage. They also assume `out_ready` is a plain level that does not depend on `out_valid` in the same cycle. The bench changes coefficients only when the pipeline is empty. It drives `out_ready` and `in_valid` half a cycle before each edge and never derives them from the block's outputs in that cycle. The accumulator-width check relies on |x| ≤ 8192, so that each Horner step grows the running sum by at most one coefficient's magnitude. Every 14-bit code satisfies this.

// File: rtl/inl_corr_pkg.sv
package inl_corr_pkg;
  // default geometry of the correction path
  localparam int DFLT_DATA_W = 14;
  localparam int DFLT_COEF_W = 18;
  localparam int DFLT_FRAC_W = 12;
  localparam int DFLT_CODE_W = 6;
  // cubic: three multiply-add steps after seeding with the top coefficient
  localparam int POLY_DEGREE = 3;
endpackage

// File: rtl/inl_horner_stage.sv
module inl_horner_stage #(
  parameter int DATA_W = 14,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_vld,
  input  logic signed [ACC_W-1:0]  in_acc,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [COEF_W-1:0] coef,
  output logic                     out_vld,
  output logic signed [ACC_W-1:0]  out_acc
);
  localparam int PROD_W = ACC_W + DATA_W;
  localparam int SHIFT  = DATA_W - 1;
  localparam int TOP_W  = PROD_W - ACC_W + 1;

  logic signed [PROD_W-1:0] acc_ext, x_ext, prod, scaled, coef_ext, sum;

  always_comb begin
    acc_ext  = {{(PROD_W-ACC_W){in_acc[ACC_W-1]}}, in_acc};
    x_ext    = {{(PROD_W-DATA_W){in_x[DATA_W-1]}}, in_x};
    coef_ext = {{(PROD_W-COEF_W){coef[COEF_W-1]}}, coef};
    prod     = acc_ext * x_ext;
    scaled   = prod >>> SHIFT;
    sum      = scaled + coef_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else if (adv) out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (adv) out_acc <= sum[ACC_W-1:0];
  end

  // R2: with |x| <= 2^SHIFT each step adds at most one coefficient magnitude,
  // so the sum must fit the accumulator without any sign loss
  p_acc_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && adv) |-> ((&sum[PROD_W-1:ACC_W-1]) || !(|sum[PROD_W-1:ACC_W-1])));

  logic unused_top;
  assign unused_top = ^sum[PROD_W-1:PROD_W-TOP_W+1] ^ 1'b0;
endmodule

// File: rtl/inl_code_quant.sv
module inl_code_quant #(
  parameter int ACC_W  = 20,
  parameter int FRAC_W = 12,
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_vld,
  input  logic signed [ACC_W-1:0]  in_acc,
  output logic                     out_vld,
  output logic [CODE_W-1:0]        out_code
);
  localparam int RND_W = ACC_W + 1;
  localparam int CMAX  = (2 ** (CODE_W - 1)) - 1;
  localparam int CMIN  = -(2 ** (CODE_W - 1));
  localparam logic signed [RND_W-1:0] HALF = RND_W'(2 ** (FRAC_W - 1));
  localparam logic signed [RND_W-1:0] HI   = RND_W'(CMAX);
  localparam logic signed [RND_W-1:0] LO   = RND_W'(CMIN);
  localparam logic signed [ACC_W-1:0] TH_HI = ACC_W'(CMAX * (2 ** FRAC_W) + 2 ** (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] TH_LO = ACC_W'(CMIN * (2 ** FRAC_W));

  logic signed [RND_W-1:0] ext, rnd;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    ext = {in_acc[ACC_W-1], in_acc};
    rnd = (ext + HALF) >>> FRAC_W;
    if (rnd > HI)      code_d = CODE_W'(CMAX);
    else if (rnd < LO) code_d = CODE_W'(CMIN);
    else               code_d = rnd[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else if (adv) out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (adv) out_code <= code_d;
  end

  // R5: anything at or above +31.5 steps lands on the top code
  p_clamp_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && adv && (in_acc >= TH_HI)) |=> (out_code == CODE_W'(CMAX)));
  // R5: anything below -32 steps lands on the bottom code
  p_clamp_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && adv && (in_acc < TH_LO)) |=> (out_code == CODE_W'(CMIN)));
endmodule

// File: rtl/inl_corr_gen.sv
module inl_corr_gen #(
  parameter int DATA_W = inl_corr_pkg::DFLT_DATA_W,
  parameter int COEF_W = inl_corr_pkg::DFLT_COEF_W,
  parameter int FRAC_W = inl_corr_pkg::DFLT_FRAC_W,
  parameter int CODE_W = inl_corr_pkg::DFLT_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_en,
  input  logic [COEF_W-1:0] coef_b0,
  input  logic [COEF_W-1:0] coef_b1,
  input  logic [COEF_W-1:0] coef_b2,
  input  logic [COEF_W-1:0] coef_b3,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code
);
  localparam int NSTG  = inl_corr_pkg::POLY_DEGREE;
  localparam int ACC_W = COEF_W + 2;

  logic                     adv;
  logic [NSTG:0]            vld;
  logic signed [ACC_W-1:0]  acc   [NSTG+1];
  logic signed [DATA_W-1:0] x_pl  [NSTG];
  logic signed [COEF_W-1:0] c_sel [NSTG];
  logic [CODE_W-1:0]        q_code;

  // whole pipeline moves together; a held output freezes every stage
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // mid-scale offset: flipping the MSB of an unsigned code gives code - 2^(N-1)
  assign x_pl[0] = {~in_code[DATA_W-1], in_code[DATA_W-2:0]};
  assign vld[0]  = in_valid;
  assign acc[0]  = {{(ACC_W-COEF_W){coef_b3[COEF_W-1]}}, coef_b3};

  // coefficients applied from the highest remaining power downwards
  assign c_sel[0] = coef_b2;
  assign c_sel[1] = coef_b1;
  assign c_sel[2] = coef_b0;

  for (genvar g = 0; g < NSTG; g++) begin : g_step
    inl_horner_stage #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W)
    ) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .in_vld (vld[g]),
      .in_acc (acc[g]),
      .in_x   (x_pl[g]),
      .coef   (c_sel[g]),
      .out_vld(vld[g+1]),
      .out_acc(acc[g+1])
    );
    if (g < NSTG - 1) begin : g_xdly
      always_ff @(posedge clk) begin
        if (adv) x_pl[g+1] <= x_pl[g];
      end
    end
  end

  inl_code_quant #(
    .ACC_W (ACC_W),
    .FRAC_W(FRAC_W),
    .CODE_W(CODE_W)
  ) u_quant (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_vld  (vld[NSTG]),
    .in_acc  (acc[NSTG]),
    .out_vld (out_valid),
    .out_code(q_code)
  );

  assign out_code = cal_en ? q_code : '0;

  // R7: a refused output keeps both its strobe and its code
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_code)));
  // R3: an accepted sample occupies the first step on the next cycle
  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> vld[1]);
  // R3: the last Horner step hands over to the quantizer without a bubble
  p_flow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld[NSTG] && adv) |=> out_valid);
endmodule

// File: tb/tb_inl_corr_gen.sv
module tb_inl_corr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_en = 1'b1;
  logic signed [17:0] cb0 = '0, cb1 = '0, cb2 = '0, cb3 = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [13:0] in_code = '0;
  logic in_ready, out_valid;
  logic [5:0] out_code;

  int checks = 0, fails = 0;
  int cyc = 0;
  int got_n = 0;
  int got_q [64];
  int got_c [64];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  inl_corr_gen dut (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en),
    .coef_b0(cb0), .coef_b1(cb1), .coef_b2(cb2), .coef_b3(cb3),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
  );

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && got_n < 64) begin
      got_q[got_n] = $signed(out_code);
      got_c[got_n] = cyc;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected code straight from the requirement formulas
  function automatic int model(input int code);
    longint x, t, r;
    x = longint'(code) - 8192;
    t = longint'(cb3);
    t = ((t * x) >>> 13) + longint'(cb2);
    t = ((t * x) >>> 13) + longint'(cb1);
    t = ((t * x) >>> 13) + longint'(cb0);
    r = (t + 2048) >>> 12;
    if (r > 31) r = 31;
    if (r < -32) r = -32;
    return int'(r);
  endfunction

  task automatic set_coefs(input int b0, input int b1, input int b2, input int b3);
    @(negedge clk);
    cb0 = 18'(b0); cb1 = 18'(b1); cb2 = 18'(b2); cb3 = 18'(b3);
  endtask

  // one sample; returns code seen and the edge count until out_valid
  task automatic one_sample(input int code, output int val, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_code = 14'(code);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    val = $signed(out_code);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_const;
    int v, l;
    set_coefs(0, 0, 0, 0);
    one_sample(5000, v, l);
    chk(v == 0, "R2 all-zero coefficients", v, 0);
    chk(l == 4, "R3 latency four edges", l, 4);
    set_coefs(5 * 4096, 0, 0, 0);
    one_sample(1234, v, l);
    chk(v == 5, "R2 constant term only", v, 5);
  endtask

  task automatic t_round;
    int v, l;
    set_coefs(10240, 0, 0, 0);
    one_sample(100, v, l);
    chk(v == 3, "R4 tie +2.5 rounds up", v, 3);
    set_coefs(-10240, 0, 0, 0);
    one_sample(100, v, l);
    chk(v == -2, "R4 tie -2.5 rounds toward +inf", v, -2);
    set_coefs(10239, 0, 0, 0);
    one_sample(100, v, l);
    chk(v == 2, "R4 just below half rounds down", v, 2);
  endtask

  task automatic t_offset;
    int v, l;
    set_coefs(7 * 4096, 4 * 4096, 0, 0);
    one_sample(8192, v, l);
    chk(v == 7, "R1 mid-scale code gives x=0", v, 7);
    one_sample(12288, v, l);
    chk(v == 9, "R1 code 12288 gives x=+4096", v, 9);
    one_sample(0, v, l);
    chk(v == 3, "R1 code 0 gives x=-8192", v, 3);
  endtask

  task automatic t_cubic;
    int v, l;
    int codes [5] = '{0, 3000, 8191, 12000, 16383};
    set_coefs(1000, 6144, -4096, 8192);
    foreach (codes[i]) begin
      one_sample(codes[i], v, l);
      chk(v == model(codes[i]), "R2 cubic Horner value", v, model(codes[i]));
    end
  endtask

  task automatic t_sat;
    int v, l;
    set_coefs(131071, 0, 0, 0);
    one_sample(42, v, l);
    chk(v == 31, "R5 clamp to +31", v, 31);
    set_coefs(-131072, -131072, 0, 0);
    one_sample(16383, v, l);
    chk(v == -32, "R5 clamp to -32", v, -32);
    chk(out_code == 6'b100000, "R5 bottom code pattern", int'(out_code), 32);
  endtask

  task automatic t_stream;
    set_coefs(2000, -9000, 3000, 5000);
    out_ready = 1'b1;
    got_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_code = 14'(i * 2047);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(got_n == 8, "R3 stream count", got_n, 8);
    chk(got_c[7] - got_c[0] == 7, "R3 one result per clock", got_c[7] - got_c[0], 7);
    for (int i = 0; i < 8; i++)
      chk(got_q[i] == model(i * 2047), "R3 stream value", got_q[i], model(i * 2047));
  endtask

  task automatic t_backpressure;
    int sent = 0;
    int cy = 0;
    set_coefs(-3000, 12000, -7000, 4000);
    got_n = 0;
    while (sent < 10 && cy < 200) begin
      @(negedge clk);
      out_ready = (cy % 3) != 1;
      in_valid = 1'b1; in_code = 14'(sent * 1601 + 77);
      #1;
      if (in_ready) sent++;
      if (out_valid && !out_ready) begin
        @(posedge clk); @(negedge clk);
        chk(out_valid == 1'b1, "R7 valid held under stall", int'(out_valid), 1);
        if (in_ready) sent++;
        cy++;
      end
      cy++;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk(got_n == 10, "R7 nothing lost or repeated", got_n, 10);
    for (int i = 0; i < 10; i++)
      chk(got_q[i] == model(i * 1601 + 77), "R7 order and value", got_q[i], model(i * 1601 + 77));
  endtask

  task automatic t_cal;
    int v, l;
    set_coefs(10 * 4096, 0, 0, 0);
    @(negedge clk);
    out_ready = 1'b0; cal_en = 1'b0;
    one_sample(900, v, l);
    chk(v == 0, "R6 output zero while disabled", v, 0);
    chk(out_valid == 1'b1, "R6 valid unaffected", int'(out_valid), 1);
    cal_en = 1'b1;
    #1;
    chk($signed(out_code) == 10, "R6 held result shows on enable", $signed(out_code), 10);
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 drained after ready", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_const();
    t_round();
    t_offset();
    t_cubic();
    t_sat();
    t_stream();
    t_backpressure();
    t_cal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule